// File: doc/BRIEF.md
# CAN receive mailbox allocator

This block sits behind a bit-level CAN receiver. Each time the receiver offers a complete frame (identifier, extended flag, remote flag, length code and eight data bytes) for one cycle, the block picks a receive mailbox and stores the frame there. A frame goes to the lowest-numbered mailbox that is configured for reception and holds no unread message. If every such mailbox is full, the lowest-numbered full mailbox configured for overwrite takes the frame instead and records that a message was lost. If no mailbox can take the frame, it is dropped and a saturating drop counter counts it.

Software uses a word-addressed register port. It sets each mailbox's mode, reads the stored identifier, status and data, and re-arms a mailbox with a control write once it has read the mailbox. A global register mirrors every mailbox's ready flag. The interrupt output is high while any ready flag is enabled in an interrupt mask, which software sets and clears through separate write-one registers. Register reads are combinational. Writes and frame captures take effect at the rising clock edge.

Each mailbox runs a three-state machine. EMPTY means it holds no message. FULL means it holds an unread message. LOST means it holds an unread message that has been overwritten at least once. The transitions are:

- store: EMPTY to FULL.
- overwrite: FULL to LOST, or LOST to LOST, when a frame arrives without a re-arm.
- rearm: FULL or LOST to EMPTY.
- rearm-with-store: any state to FULL, when a re-arm and a frame hit the same mailbox in one cycle.

Global page at word addresses 0 to 4:

| Address | Access | Contents |
|---|---|---|
| 0 | read | ready vector |
| 1 | write | mask set, one bit per mailbox |
| 2 | write | mask clear, one bit per mailbox |
| 3 | read | mask |
| 4 | read | drop count |

Mailbox i occupies the page at word address 8*(i+1). Offsets within the page:

| Offset | Contents |
|---|---|
| 0 | mode |
| 1 | identifier |
| 2 | status |
| 3 | low data word |
| 4 | high data word |
| 5 | control, write only |

Top module: `can_rx_mailbox`

## Requirements
- R1: A frame offered with `frm_valid` is stored, at that clock edge, into the lowest-numbered mailbox whose mode is receive (1) or receive-with-overwrite (2) and whose ready flag is 0. That mailbox's ready flag becomes 1.
- R2: A mailbox's mode is the 3-bit field at bits 26:24 of its mode register (offset 0), and reads back as written. After reset every mode is 0. A mailbox whose mode is any value other than 1 or 2 never receives a frame.
- R3: A mailbox with ready set keeps its content and its ready flag until a control write (offset 5) with bit 23 set. That write clears ready and frees the mailbox. A control write with bit 23 clear has no effect.
- R4: The status register (offset 2) holds the length code in bits 19:16, the remote flag in bit 20, ready in bit 23 and message-lost in bit 24. All other bits read 0.
- R5: The identifier register (offset 1) has bit 29 set for an extended frame, with the 29-bit identifier in bits 28:0. For a standard frame bit 29 is 0, the 11-bit identifier sits in bits 28:18 and bits 17:0 are 0.
- R6: The low data word (offset 3) holds data bytes 0 to 3 and the high data word (offset 4) holds bytes 4 to 7. Byte k of each group sits in bits 8k+7:8k.
- R7: When no free receive mailbox exists, the lowest-numbered full mailbox in mode 2 is overwritten with the new frame and its message-lost bit is set. Re-arming that mailbox clears both ready and message-lost.
- R8: A frame that no mailbox can take is dropped without changing any mailbox. The drop counter at global address 4 then increments, saturating at 255.
- R9: Global address 0 bit i equals mailbox i's ready flag. A write to address 1 sets the mask bits that are 1 in the data, a write to address 2 clears them, and address 3 reads the mask. The mask resets to 0. `irq` is 1 exactly when some mailbox has both ready and mask set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A received frame is offered this cycle |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_id | input | 29 | Identifier, right-aligned (11 bits for a standard frame) |
| frm_rtr | input | 1 | Remote request flag |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte k in bits 8k+7:8k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked ready interrupt |

## Verification
The assertions check the following on every cycle:
- at most one mailbox is written per cycle;
- an offered frame is either placed or counted as dropped;
- ready flags rise only when a frame arrives;
- stored content stays unchanged without a store;
- a re-arm frees its mailbox;
- an overwrite sets message-lost;
- the drop count steps by one;
- mask set and clear writes take effect.

Only the bench's scenarios can show the other properties:
- that the chosen mailbox is the lowest-numbered eligible one under varied mode and occupancy patterns;
- that modes other than 1 and 2 are skipped;
- that the identifier, status and data words are laid out as specified;
- that the drop counter saturates.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;

    localparam int MODE_W = 3;

    // mode codes
    localparam logic [MODE_W-1:0] MODE_RX     = 3'd1;
    localparam logic [MODE_W-1:0] MODE_RX_OVR = 3'd2;

    // register field positions
    localparam int MODE_LSB       = 24;
    localparam int ST_DLC_LSB     = 16;
    localparam int ST_RTR_BIT     = 20;
    localparam int ST_RDY_BIT     = 23;
    localparam int ST_LOST_BIT    = 24;
    localparam int CTRL_REARM_BIT = 23;

    // offsets inside a mailbox page
    localparam logic [2:0] OFF_MODE = 3'd0;
    localparam logic [2:0] OFF_ID   = 3'd1;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_DLO  = 3'd3;
    localparam logic [2:0] OFF_DHI  = 3'd4;
    localparam logic [2:0] OFF_CTRL = 3'd5;

    // offsets inside the global page
    localparam logic [2:0] G_READY = 3'd0;
    localparam logic [2:0] G_MSET  = 3'd1;
    localparam logic [2:0] G_MCLR  = 3'd2;
    localparam logic [2:0] G_MASK  = 3'd3;
    localparam logic [2:0] G_DROP  = 3'd4;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_FULL  = 2'd1,
        SLOT_LOST  = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
    } rx_frame_t;

endpackage

// File: rtl/can_rxmb_slot.sv
module can_rxmb_slot
    import can_rxmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              rearm,
    input  logic              store,
    input  rx_frame_t         frm,
    output logic [MODE_W-1:0] mode,
    output logic              ready,
    output logic              lost,
    output logic [31:0]       id_word,
    output logic [31:0]       status_word,
    output logic [31:0]       data_lo,
    output logic [31:0]       data_hi
);

    slot_state_e       state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [29:0]       id_q;
    logic              rtr_q;
    logic [3:0]        dlc_q;
    logic [63:0]       data_q;
    logic [29:0]       id_enc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (store) state_d = SLOT_FULL;
            end
            SLOT_FULL, SLOT_LOST: begin
                if (store)      state_d = rearm ? SLOT_FULL : SLOT_LOST;
                else if (rearm) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        ready = (state_q != SLOT_EMPTY);
        lost  = (state_q == SLOT_LOST);
        status_word = '0;
        status_word[ST_DLC_LSB +: 4] = dlc_q;
        status_word[ST_RTR_BIT]      = rtr_q;
        status_word[ST_RDY_BIT]      = ready;
        status_word[ST_LOST_BIT]     = lost;
    end

    assign id_enc  = frm.ext ? {1'b1, frm.id} : {1'b0, frm.id[10:0], 18'd0};
    assign id_word = {2'b00, id_q};
    assign data_lo = data_q[31:0];
    assign data_hi = data_q[63:32];
    assign mode    = mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= mode_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            rtr_q  <= 1'b0;
            dlc_q  <= '0;
            data_q <= '0;
        end else if (store) begin
            id_q   <= id_enc;
            rtr_q  <= frm.rtr;
            dlc_q  <= frm.dlc;
            data_q <= frm.data;
        end
    end

    assert_store_sets_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> ready);

    assert_rearm_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !store) |=> (!ready && !lost));

    assert_content_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> ($stable(id_q) && $stable(data_q) && $stable(dlc_q) && $stable(rtr_q)));

    assert_overwrite_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store && ready && !rearm) |=> lost);

endmodule

// File: rtl/can_rxmb_pick.sv
module can_rxmb_pick #(
    parameter int N = 8
) (
    input  logic         valid,
    input  logic [N-1:0] rx_en,
    input  logic [N-1:0] ovr_en,
    input  logic [N-1:0] ready,
    output logic [N-1:0] grant,
    output logic         drop
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] free_v, full_ovr, low_free, low_ovr;

    always_comb begin
        free_v   = rx_en & ~ready;
        full_ovr = ovr_en & ready;
        // isolate the least significant set bit
        low_free = free_v & ((~free_v) + ONE);
        low_ovr  = full_ovr & ((~full_ovr) + ONE);
        grant    = '0;
        drop     = 1'b0;
        if (valid) begin
            if (|free_v)        grant = low_free;
            else if (|full_ovr) grant = low_ovr;
            else                drop  = 1'b1;
        end
    end

endmodule

// File: rtl/can_rxmb_irq.sv
module can_rxmb_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] bits,
    input  logic [N-1:0] ready,
    output logic [N-1:0] mask,
    output logic         irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask & ~(clr_we ? bits : '0)) | (set_we ? bits : '0);
    end

    assign irq = |(ready & mask);

    assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(bits)) == $past(bits)));

    assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(bits)) == '0));

endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
    import can_rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [28:0]       frm_id,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int PAGE_W = ADDR_W - 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PAGE_W-1:0] page;
    logic [2:0]        off;
    rx_frame_t         frm;
    logic [NUM_MB-1:0] rx_en, ovr_en, ready_v, lost_v, grant, mask;
    logic              drop;
    logic [CNT_W-1:0]  drop_cnt;
    logic              mset_we, mclr_we;
    logic              unused_wdata;

    logic [MODE_W-1:0] mb_mode [NUM_MB];
    logic [31:0]       mb_id   [NUM_MB];
    logic [31:0]       mb_stat [NUM_MB];
    logic [31:0]       mb_dlo  [NUM_MB];
    logic [31:0]       mb_dhi  [NUM_MB];

    assign page = reg_addr[ADDR_W-1:3];
    assign off  = reg_addr[2:0];
    assign frm  = '{ext: frm_ext, id: frm_id, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};
    assign unused_wdata = ^reg_wdata;

    assign mset_we = reg_wr && (page == '0) && (off == G_MSET);
    assign mclr_we = reg_wr && (page == '0) && (off == G_MCLR);

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic sel;
        assign sel       = reg_wr && (page == PAGE_W'(i + 1));
        assign rx_en[i]  = (mb_mode[i] == MODE_RX) || (mb_mode[i] == MODE_RX_OVR);
        assign ovr_en[i] = (mb_mode[i] == MODE_RX_OVR);

        can_rxmb_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_we     (sel && (off == OFF_MODE)),
            .mode_wdata  (reg_wdata[MODE_LSB +: MODE_W]),
            .rearm       (sel && (off == OFF_CTRL) && reg_wdata[CTRL_REARM_BIT]),
            .store       (grant[i]),
            .frm         (frm),
            .mode        (mb_mode[i]),
            .ready       (ready_v[i]),
            .lost        (lost_v[i]),
            .id_word     (mb_id[i]),
            .status_word (mb_stat[i]),
            .data_lo     (mb_dlo[i]),
            .data_hi     (mb_dhi[i])
        );
    end

    can_rxmb_pick #(.N(NUM_MB)) u_pick (
        .valid  (frm_valid),
        .rx_en  (rx_en),
        .ovr_en (ovr_en),
        .ready  (ready_v),
        .grant  (grant),
        .drop   (drop)
    );

    can_rxmb_irq #(.N(NUM_MB)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (mset_we),
        .clr_we (mclr_we),
        .bits   (reg_wdata[NUM_MB-1:0]),
        .ready  (ready_v),
        .mask   (mask),
        .irq    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           drop_cnt <= '0;
        else if (drop && (drop_cnt != CNT_MAX)) drop_cnt <= drop_cnt + 1'b1;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (page == '0) begin
            case (off)
                G_READY: reg_rdata = 32'(ready_v);
                G_MASK:  reg_rdata = 32'(mask);
                G_DROP:  reg_rdata = 32'(drop_cnt);
                default: reg_rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_MB; i++) begin
                if (page == PAGE_W'(i + 1)) begin
                    case (off)
                        OFF_MODE: reg_rdata = 32'(mb_mode[i]) << MODE_LSB;
                        OFF_ID:   reg_rdata = mb_id[i];
                        OFF_STAT: reg_rdata = mb_stat[i];
                        OFF_DLO:  reg_rdata = mb_dlo[i];
                        OFF_DHI:  reg_rdata = mb_dhi[i];
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assert_single_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_frame_placed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !drop) |-> $onehot(grant));

    assert_drop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && (drop_cnt != CNT_MAX)) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

    assert_ready_needs_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> ((ready_v & ~$past(ready_v)) == '0));

    assert_lost_implies_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lost_v & ~ready_v) == '0));

endmodule

// File: tb/can_rx_mailbox_bench.sv
module can_rx_mailbox_bench;

    localparam int N        = 8;
    localparam int DROP_MAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    can_rx_mailbox u_can_rx_mailbox (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
        .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;

    // reference model
    int          m_mode [N];
    bit          m_rdy  [N];
    bit          m_lost [N];
    logic [31:0] m_idw  [N];
    bit          m_rtr  [N];
    logic [3:0]  m_dlc  [N];
    logic [31:0] m_lo   [N];
    logic [31:0] m_hi   [N];
    logic [N-1:0] m_mask = '0;
    int          m_drop = 0;
    int          last_tgt;

    task automatic check(string r, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc_id(bit ext, logic [28:0] id);
        return ext ? {3'b001, id} : {3'b000, id[10:0], 18'd0};
    endfunction

    function automatic logic [31:0] exp_status(int i);
        return (32'(m_lost[i]) << 24) | (32'(m_rdy[i]) << 23) |
               (32'(m_rtr[i]) << 20) | (32'(m_dlc[i]) << 16);
    endfunction

    function automatic int pick();
        for (int i = 0; i < N; i++)
            if ((m_mode[i] == 1 || m_mode[i] == 2) && !m_rdy[i]) return i;
        for (int i = 0; i < N; i++)
            if (m_mode[i] == 2 && m_rdy[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] rdy_vec();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = m_rdy[i];
        return v;
    endfunction

    task automatic send(bit ext, logic [28:0] id, bit rtr, logic [3:0] dlc, logic [63:0] d);
        int t;
        t = pick();
        frm_ext = ext; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = d;
        frm_valid = 1'b1;
        tick();
        frm_valid = 1'b0;
        if (t < 0) begin
            if (m_drop < DROP_MAX) m_drop++;
        end else begin
            m_lost[t] = m_rdy[t];
            m_rdy[t]  = 1'b1;
            m_idw[t]  = enc_id(ext, id);
            m_rtr[t]  = rtr;
            m_dlc[t]  = dlc;
            m_lo[t]   = d[31:0];
            m_hi[t]   = d[63:32];
        end
        last_tgt = t;
    endtask

    task automatic set_mode(int i, int m);
        wr(8'(8 * (i + 1)), 32'(m) << 24);
        m_mode[i] = m;
    endtask

    task automatic rearm(int i, bit go);
        wr(8'(8 * (i + 1) + 5), go ? 32'h0080_0000 : 32'hFF7F_FFFF);
        if (go) begin m_rdy[i] = 1'b0; m_lost[i] = 1'b0; end
    endtask

    task automatic check_mb(int i, string r);
        logic [31:0] v;
        rd(8'(8 * (i + 1) + 1), v); check({r, " id"}, v, m_idw[i]);
        rd(8'(8 * (i + 1) + 2), v); check({r, " status"}, v, exp_status(i));
        rd(8'(8 * (i + 1) + 3), v); check({r, " data lo"}, v, m_lo[i]);
        rd(8'(8 * (i + 1) + 4), v); check({r, " data hi"}, v, m_hi[i]);
    endtask

    task automatic check_glob(string r);
        logic [31:0] v;
        rd(8'd0, v); check({r, " R9 ready vector"}, v, 32'(rdy_vec()));
        rd(8'd3, v); check({r, " R9 mask"}, v, 32'(m_mask));
        rd(8'd4, v); check({r, " R8 drop count"}, v, 32'(m_drop));
        check({r, " R9 irq"}, 32'(irq), 32'(|(rdy_vec() & m_mask)));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int modes [4] = '{0, 1, 2, 5};
        void'($urandom(32'd5150));
        for (int i = 0; i < N; i++) begin
            m_mode[i] = 0; m_rdy[i] = 0; m_lost[i] = 0; m_idw[i] = '0;
            m_rtr[i] = 0; m_dlc[i] = '0; m_lo[i] = '0; m_hi[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check_glob("reset");
        rd(8'd8, v); check("R2 reset mode", v, 32'd0);

        // all modes off: frame dropped
        send(1'b0, 29'h123, 1'b0, 4'd2, 64'h1122);
        check("R2 no receive when mode 0", 32'(last_tgt), 32'hFFFF_FFFF);
        check_glob("R8 drop with modes off");

        // configure modes
        for (int i = 0; i < N; i++) set_mode(i, 1);
        set_mode(3, 5);
        set_mode(7, 2);
        rd(8'(8 * 4), v); check("R2 mode readback", v, 32'h0500_0000);

        // standard frame into mailbox 0
        send(1'b0, 29'h5A3, 1'b0, 4'd8, 64'h8877_6655_4433_2211);
        check("R1 first frame target", 32'(last_tgt), 32'd0);
        check_mb(0, "R5 R6 R4 std frame");
        // extended remote frame into mailbox 1
        send(1'b1, 29'h1ABC_DEF0, 1'b1, 4'd0, 64'h0);
        check_mb(1, "R5 R4 ext remote frame");

        // control write without bit 23: no effect
        rearm(0, 1'b0);
        check_mb(0, "R3 rearm without bit23");

        // fill the rest; mailbox 3 (mode 5) skipped
        for (int k = 0; k < 5; k++)
            send(k[0], 29'(32'h100 + k), 1'b0, 4'(k + 1), rnd64());
        rd(8'd0, v); check("R2 mode 5 skipped", v, 32'h0000_00F7);
        // everything full: overwrite mailbox 7
        send(1'b0, 29'h7FF, 1'b0, 4'd5, 64'hDEAD_BEEF_CAFE_F00D);
        check("R7 overwrite target", 32'(last_tgt), 32'd7);
        check_mb(7, "R7 overwrite content");
        check_mb(6, "R3 full mailbox untouched");

        // free mailbox 1: next frame lands there
        rearm(1, 1'b1);
        check_glob("R3 rearm clears ready");
        send(1'b1, 29'h0000_0001, 1'b0, 4'd3, 64'h0102_0304_0506_0708);
        check("R1 lowest free after rearm", 32'(last_tgt), 32'd1);
        check_mb(1, "R6 data after rearm");

        // rearm overwrite mailbox clears lost
        rearm(7, 1'b1);
        check_mb(7, "R7 rearm clears lost");

        // mask and irq
        wr(8'd1, 32'h0000_0002); m_mask[1] = 1'b1;
        check_glob("R9 mask set");
        wr(8'd2, 32'h0000_0002); m_mask[1] = 1'b0;
        check_glob("R9 mask clear");
        wr(8'd1, 32'h0000_0080); m_mask[7] = 1'b1;
        check_glob("R9 mask on empty mailbox");

        // constrained random phase
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(99);
            if (r < 55) begin
                send(1'($urandom()), 29'($urandom()), 1'($urandom()), 4'($urandom()), rnd64());
            end else if (r < 80) begin
                rearm($urandom_range(N - 1), 1'($urandom_range(3) != 0));
            end else if (r < 90) begin
                logic [N-1:0] b;
                b = N'($urandom());
                if ($urandom_range(1) == 1) begin wr(8'd1, 32'(b)); m_mask |= b; end
                else begin wr(8'd2, 32'(b)); m_mask &= ~b; end
            end else begin
                set_mode($urandom_range(N - 1), modes[$urandom_range(3)]);
            end
            check_glob("R1 R3 R7 R9 random");
            if (it % 16 == 0) check_mb($urandom_range(N - 1), "R4 R5 R6 random");
        end

        // saturation of the drop counter: no overwrite mailbox, all full
        for (int i = 0; i < N; i++) set_mode(i, 1);
        for (int k = 0; k < 270; k++) send(1'b0, 29'(k), 1'b0, 4'd1, 64'(k));
        check_glob("R8 drop saturation");
        rd(8'd4, v); check("R8 drop counter saturates at 255", v, 32'd255);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule